// File: doc/BRIEF.md
# Banked Serial Controller Register Interface

This block is the host-facing register file of a 16550-style serial controller. The host reaches it through a byte-wide port with a 3-bit offset. The meaning of offsets 0, 1, 2 and 7 depends on what the line control register currently holds. When its top bit is set, offsets 0 and 1 reach the two divisor bytes. When it holds exactly 0xBF, offset 2 reaches an enhanced-feature register and offset 7 stops showing the scratch byte.

On the line side, the block holds a receive queue and a transmit queue. An external serializer pushes received bytes into the receive queue with a valid strobe. It takes bytes from the transmit queue with a valid/ready pair. The block drives DTR, RTS and an interrupt output, each from a register. It exports the 16-bit divisor and the frame settings to the baud generator and the shifter, which live outside this block.

Top module: `sercom_regbank`

## Requirements
- R1: After reset, reading offset 2 returns 0x01, offset 5 returns 0x60 and offset 3 returns 0x00; irq_out, rts_out, dtr_out and tx_valid are 0.
- R2: While line-control bit 7 is 1, offsets 0 and 1 read and write the low and high divisor bytes, and `divisor` = {high, low}. While that bit is 0, offset 1 reads and writes the interrupt-enable register (4 bits, returned in bits 3:0).
- R3: While line control equals 0xBF, offset 2 reads and writes the enhanced-feature register. In the same mode, offset 7 reads 0x00 and writes to it are ignored, so the scratch byte is intact once line control changes.
- R4: In normal mode, offset 7 stores any written byte and returns it.
- R5: A write to offset 2 (FIFO control) sets the queue enable from bit 0 and the trigger code from bits 7:6. Bit 1 empties the receive queue and bit 2 empties the transmit queue. Bits 7:6 of offset 2 on read equal the queue enable, twice.
- R6: FIFO control bit 5 selects deep mode and is stored only if line-control bit 7 is 1 at the write. Read bit 5 of offset 2 is deep mode AND queue enable.
- R7: Reading offset 0 in normal mode returns the oldest received byte and removes it. Status (offset 5) bit 0 is 1 exactly when bytes are waiting. A read of an empty queue returns 0x00.
- R8: A write to offset 0 in normal mode queues a byte for tx_byte/tx_valid, and tx_ready pops it. Queue capacity is 1 with the queue disabled, DEPTH/4 when enabled and shallow, and DEPTH when deep. Status bit 5 is 1 while the transmit queue holds fewer than capacity, and bit 6 while it is empty. Writes to a full queue are dropped.
- R9: A received byte arriving while the receive queue is at capacity is discarded and sets status bit 1. A status read clears bit 1.
- R10: Offset 2 read bits 3:0 are 0x4 while interrupt-enable bit 0 is set and the receive level reaches the threshold, else 0x1. The threshold is 1 with the queue disabled; with it enabled, trigger codes 0/1/2/3 give 1, cap/4, cap/2 and cap−cap/8. irq_out is that condition AND modem-control bit 3, one cycle later; otherwise irq_out is 0.
- R11: dtr_out follows modem-control bit 0 and rts_out bit 1, one cycle later. When automatic RTS is on (modem-control bit 5 or enhanced bit 6), rts_out drops while the receive level reaches the threshold.
- R12: Offset 6 bit 4 is the registered CTS level. Bit 0 is set on any CTS change and cleared by reading offset 6. When automatic CTS is on (modem-control bit 5 or enhanced bit 7), tx_valid is held low while CTS is low.
- R13: frame_cfg equals line-control bits 6:0 (word length 1:0, stop 2, parity 5:3, break 6).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_en | input | 1 | Host access strobe, one cycle per access |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 3 | Register offset |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, valid the cycle after a read strobe |
| rx_valid | input | 1 | Serializer delivers a received byte |
| rx_byte | input | 8 | Received byte |
| tx_valid | output | 1 | Transmit byte available and allowed |
| tx_byte | output | 8 | Oldest queued transmit byte |
| tx_ready | input | 1 | Serializer takes tx_byte |
| cts_in | input | 1 | Clear-to-send level |
| rts_out | output | 1 | Request-to-send |
| dtr_out | output | 1 | Data-terminal-ready |
| irq_out | output | 1 | Interrupt, active high, driven 0 when gated off |
| divisor | output | 16 | Baud divisor {high, low} |
| frame_cfg | output | 7 | Word length, stop, parity, break settings |

## Verification
The bench targets bank aliasing. A decoder that ignored the exact 0xBF match would leak the scratch byte or let offset-7 writes overwrite it. A decoder that ignored bit 7 would write the divisor into the interrupt-enable register. Deep-mode writes with bit 7 clear must leave IIR bit 5 unchanged, or a careless write path would silently drop deep mode. Further checks cover capacity edges: the sixteenth transmit byte must clear the room flag, a second byte with the queue disabled must set overrun and be discarded, and raising the trigger level must withdraw a pending interrupt and RTS drop.

// File: rtl/sercom_pkg.sv
package sercom_pkg;

  // Decoded register target after bank selection
  typedef enum logic [3:0] {
    RS_DATA, RS_DLL, RS_DLM, RS_IER, RS_IIR_FCR, RS_EFR,
    RS_LCR, RS_MCR, RS_LSR, RS_MSR, RS_SCR, RS_HIDDEN
  } regsel_t;

  localparam logic [7:0] EFR_KEY = 8'hBF;

  // Offset plus current line control selects the target register
  function automatic regsel_t decode_sel(input logic [2:0] ofs, input logic [7:0] lcr);
    logic div_bank;
    logic efr_bank;
    regsel_t s;
    div_bank = lcr[7];
    efr_bank = (lcr == EFR_KEY);
    case (ofs)
      3'd0:    s = div_bank ? RS_DLL : RS_DATA;
      3'd1:    s = div_bank ? RS_DLM : RS_IER;
      3'd2:    s = efr_bank ? RS_EFR : RS_IIR_FCR;
      3'd3:    s = RS_LCR;
      3'd4:    s = RS_MCR;
      3'd5:    s = RS_LSR;
      3'd6:    s = RS_MSR;
      default: s = efr_bank ? RS_HIDDEN : RS_SCR;
    endcase
    return s;
  endfunction

  // Receive threshold for a given capacity and trigger code
  function automatic logic [7:0] rx_threshold(input logic [7:0] cap, input logic [1:0] code);
    logic [7:0] t;
    case (code)
      2'd0:    t = 8'd1;
      2'd1:    t = cap >> 2;
      2'd2:    t = cap >> 1;
      default: t = cap - (cap >> 3);
    endcase
    return t;
  endfunction

endpackage

// File: rtl/sercom_fifo.sv
module sercom_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] head,
  output logic [CW-1:0]    level
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    cnt;
  logic             do_push, do_pop;

  assign do_push = push && (cnt != CW'(DEPTH));
  assign do_pop  = pop && (cnt != '0);

  // storage without reset so it can map to RAM
  always_ff @(posedge clk) begin
    if (do_push && !clear) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign head  = mem[rd_ptr];
  assign level = cnt;

endmodule

// File: rtl/sercom_ctrl.sv
module sercom_ctrl
  import sercom_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  regsel_t    sel,
  input  logic [7:0] wdata,
  output logic [7:0] lcr_q,
  output logic [5:0] mcr_q,
  output logic [3:0] ier_q,
  output logic [7:0] dll_q,
  output logic [7:0] dlm_q,
  output logic [7:0] efr_q,
  output logic [7:0] scr_q,
  output logic       fifo_on,
  output logic       deep_on,
  output logic [1:0] trig_code,
  output logic       tx_push,
  output logic       rx_flush,
  output logic       tx_flush
);

  logic fcr_wr;
  assign fcr_wr   = wr_en && (sel == RS_IIR_FCR);
  assign tx_push  = wr_en && (sel == RS_DATA);
  assign rx_flush = fcr_wr && wdata[1];
  assign tx_flush = fcr_wr && wdata[2];

  always_ff @(posedge clk) begin
    if (rst) begin
      lcr_q     <= '0;
      mcr_q     <= '0;
      ier_q     <= '0;
      dll_q     <= '0;
      dlm_q     <= '0;
      efr_q     <= '0;
      scr_q     <= '0;
      fifo_on   <= 1'b0;
      deep_on   <= 1'b0;
      trig_code <= '0;
    end else if (wr_en) begin
      case (sel)
        RS_DLL: dll_q <= wdata;
        RS_DLM: dlm_q <= wdata;
        RS_IER: ier_q <= wdata[3:0];
        RS_IIR_FCR: begin
          fifo_on   <= wdata[0];
          trig_code <= wdata[7:6];
          if (lcr_q[7]) deep_on <= wdata[5];
        end
        RS_EFR: efr_q <= wdata;
        RS_LCR: lcr_q <= wdata;
        RS_MCR: mcr_q <= wdata[5:0];
        RS_SCR: scr_q <= wdata;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/sercom_lines.sv
module sercom_lines (
  input  logic       clk,
  input  logic       rst,
  input  logic       dtr_bit,
  input  logic       rts_bit,
  input  logic       irq_gate,
  input  logic       auto_bit,
  input  logic [1:0] efr_auto,
  input  logic       cts_in,
  input  logic       rx_hit,
  input  logic       irq_hit,
  input  logic       tx_nonempty,
  input  logic       msr_rd,
  output logic       dtr_out,
  output logic       rts_out,
  output logic       irq_out,
  output logic       cts_q,
  output logic       dcts_q,
  output logic       tx_valid
);

  logic auto_rts, auto_cts;
  assign auto_rts = auto_bit | efr_auto[0];
  assign auto_cts = auto_bit | efr_auto[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      dtr_out <= 1'b0;
      rts_out <= 1'b0;
      irq_out <= 1'b0;
      cts_q   <= 1'b0;
      dcts_q  <= 1'b0;
    end else begin
      dtr_out <= dtr_bit;
      rts_out <= rts_bit && !(auto_rts && rx_hit);
      irq_out <= irq_gate && irq_hit;
      cts_q   <= cts_in;
      if (cts_in != cts_q) dcts_q <= 1'b1;
      else if (msr_rd)     dcts_q <= 1'b0;
    end
  end

  assign tx_valid = tx_nonempty && (!auto_cts || cts_q);

endmodule

// File: rtl/sercom_regbank.sv
module sercom_regbank
  import sercom_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        host_en,
  input  logic        host_we,
  input  logic [2:0]  host_addr,
  input  logic [7:0]  host_wdata,
  output logic [7:0]  host_rdata,
  input  logic        rx_valid,
  input  logic [7:0]  rx_byte,
  output logic        tx_valid,
  output logic [7:0]  tx_byte,
  input  logic        tx_ready,
  input  logic        cts_in,
  output logic        rts_out,
  output logic        dtr_out,
  output logic        irq_out,
  output logic [15:0] divisor,
  output logic [6:0]  frame_cfg
);

  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [7:0] CAP_DEEP    = 8'(DEPTH);
  localparam logic [7:0] CAP_SHALLOW = 8'(DEPTH / 4);

  regsel_t    sel;
  logic       wr, rd;
  logic [7:0] lcr_q, dll_q, dlm_q, efr_q, scr_q;
  logic [5:0] mcr_q;
  logic [3:0] ier_q;
  logic       fifo_on, deep_on;
  logic [1:0] trig_code;
  logic       ctrl_tx_push, rx_flush, tx_flush;
  logic [7:0] cap8, thr8;
  logic [CW-1:0] cap, thr;
  logic [CW-1:0] rx_level, tx_level;
  logic [7:0] rx_head;
  logic       rx_push, rx_pop, tx_push, tx_pop, overrun_evt;
  logic       rx_hit, irq_pend, oe_q;
  logic       lsr_rd, msr_rd, cts_q, dcts_q;
  logic [7:0] lsr_val, iir_val, msr_val;

  assign sel = decode_sel(host_addr, lcr_q);
  assign wr  = host_en && host_we;
  assign rd  = host_en && !host_we;

  sercom_ctrl u_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr), .sel(sel), .wdata(host_wdata),
    .lcr_q(lcr_q), .mcr_q(mcr_q), .ier_q(ier_q), .dll_q(dll_q), .dlm_q(dlm_q),
    .efr_q(efr_q), .scr_q(scr_q), .fifo_on(fifo_on), .deep_on(deep_on),
    .trig_code(trig_code), .tx_push(ctrl_tx_push), .rx_flush(rx_flush),
    .tx_flush(tx_flush)
  );

  // queue capacity and receive threshold follow the FIFO control settings
  assign cap8 = fifo_on ? (deep_on ? CAP_DEEP : CAP_SHALLOW) : 8'd1;
  assign thr8 = fifo_on ? rx_threshold(cap8, trig_code) : 8'd1;
  assign cap  = CW'(cap8);
  assign thr  = CW'(thr8);

  assign rx_push     = rx_valid && (rx_level < cap);
  assign overrun_evt = rx_valid && (rx_level >= cap);
  assign rx_pop      = rd && (sel == RS_DATA);
  assign tx_push     = ctrl_tx_push && (tx_level < cap);
  assign tx_pop      = tx_valid && tx_ready;
  assign lsr_rd      = rd && (sel == RS_LSR);
  assign msr_rd      = rd && (sel == RS_MSR);

  sercom_fifo #(.WIDTH(8), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .clear(rx_flush), .push(rx_push), .pop(rx_pop),
    .wdata(rx_byte), .head(rx_head), .level(rx_level)
  );

  sercom_fifo #(.WIDTH(8), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst(rst), .clear(tx_flush), .push(tx_push), .pop(tx_pop),
    .wdata(host_wdata), .head(tx_byte), .level(tx_level)
  );

  assign rx_hit   = (rx_level >= thr);
  assign irq_pend = ier_q[0] && rx_hit;

  sercom_lines u_lines (
    .clk(clk), .rst(rst), .dtr_bit(mcr_q[0]), .rts_bit(mcr_q[1]),
    .irq_gate(mcr_q[3]), .auto_bit(mcr_q[5]), .efr_auto(efr_q[7:6]),
    .cts_in(cts_in), .rx_hit(rx_hit), .irq_hit(irq_pend),
    .tx_nonempty(tx_level != '0), .msr_rd(msr_rd), .dtr_out(dtr_out),
    .rts_out(rts_out), .irq_out(irq_out), .cts_q(cts_q), .dcts_q(dcts_q),
    .tx_valid(tx_valid)
  );

  // overrun flag: a new event wins over a clearing read
  always_ff @(posedge clk) begin
    if (rst)              oe_q <= 1'b0;
    else if (overrun_evt) oe_q <= 1'b1;
    else if (lsr_rd)      oe_q <= 1'b0;
  end

  assign lsr_val = {1'b0, tx_level == '0, tx_level < cap, 3'b000, oe_q, rx_level != '0};
  assign iir_val = {fifo_on, fifo_on, fifo_on && deep_on, 1'b0, irq_pend ? 4'h4 : 4'h1};
  assign msr_val = {3'b000, cts_q, 3'b000, dcts_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rdata <= '0;
    end else if (rd) begin
      case (sel)
        RS_DATA:    host_rdata <= (rx_level != '0) ? rx_head : 8'h00;
        RS_DLL:     host_rdata <= dll_q;
        RS_DLM:     host_rdata <= dlm_q;
        RS_IER:     host_rdata <= {4'h0, ier_q};
        RS_IIR_FCR: host_rdata <= iir_val;
        RS_EFR:     host_rdata <= efr_q;
        RS_LCR:     host_rdata <= lcr_q;
        RS_MCR:     host_rdata <= {2'b00, mcr_q};
        RS_LSR:     host_rdata <= lsr_val;
        RS_MSR:     host_rdata <= msr_val;
        RS_SCR:     host_rdata <= scr_q;
        default:    host_rdata <= 8'h00;
      endcase
    end
  end

  assign divisor   = {dlm_q, dll_q};
  assign frame_cfg = lcr_q[6:0];

endmodule

// File: rtl/sercom_regbank_chk.sv
module sercom_regbank_chk #(
  parameter int CW = 7,
  parameter int DEPTH = 64
) (
  input logic          clk,
  input logic          rst,
  input logic          host_en,
  input logic          host_we,
  input logic [2:0]    host_addr,
  input logic [7:0]    host_wdata,
  input logic [7:0]    host_rdata,
  input logic          irq_out,
  input logic          rts_out,
  input logic          dtr_out,
  input logic [15:0]   divisor,
  input logic [7:0]    lcr_q,
  input logic [5:0]    mcr_q,
  input logic [CW-1:0] rx_level
);

  // R1: outputs come out of reset quiet
  p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!irq_out && !rts_out && !dtr_out && host_rdata == 8'h00));

  // R2: divisor low byte takes the written value while the divisor bank is open
  p_divisor_low_r2: assert property (@(posedge clk) disable iff (rst)
    (host_en && host_we && host_addr == 3'd0 && lcr_q[7]) |=> divisor[7:0] == $past(host_wdata));

  // R3: scratch is hidden in the enhanced bank
  p_hidden_scratch_r3: assert property (@(posedge clk) disable iff (rst)
    (host_en && !host_we && host_addr == 3'd7 && lcr_q == 8'hBF) |=> host_rdata == 8'h00);

  // R7: empty receive read yields zero
  p_empty_read_r7: assert property (@(posedge clk) disable iff (rst)
    (host_en && !host_we && host_addr == 3'd0 && !lcr_q[7] && rx_level == '0) |=> host_rdata == 8'h00);

  // R9: receive level never exceeds physical storage
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
    rx_level <= CW'(DEPTH));

  // R10: interrupt only with data held and the gate bit set
  p_irq_needs_data_r10: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> ($past(rx_level) != '0 && $past(mcr_q[3])));

  // R11: RTS never asserted without its modem-control bit
  p_rts_needs_bit_r11: assert property (@(posedge clk) disable iff (rst)
    $past(!mcr_q[1]) |-> !rts_out);

  // R11: DTR is 0 after its bit was 0
  p_dtr_needs_bit_r11: assert property (@(posedge clk) disable iff (rst)
    $past(!mcr_q[0]) |-> !dtr_out);

endmodule

bind sercom_regbank sercom_regbank_chk #(.CW(CW), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .host_en(host_en), .host_we(host_we),
  .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
  .irq_out(irq_out), .rts_out(rts_out), .dtr_out(dtr_out), .divisor(divisor),
  .lcr_q(lcr_q), .mcr_q(mcr_q), .rx_level(rx_level)
);

// File: tb/sim_sercom_regbank.sv
`timescale 1ns/1ps
module sim_sercom_regbank;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_en = 1'b0, host_we = 1'b0;
  logic [2:0]  host_addr = '0;
  logic [7:0]  host_wdata = '0;
  logic [7:0]  host_rdata;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        tx_valid;
  logic [7:0]  tx_byte;
  logic        tx_ready = 1'b0;
  logic        cts_in = 1'b0;
  logic        rts_out, dtr_out, irq_out;
  logic [15:0] divisor;
  logic [6:0]  frame_cfg;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  sercom_regbank #(.DEPTH(64)) u0 (
    .clk(clk), .rst(rst), .host_en(host_en), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .tx_valid(tx_valid), .tx_byte(tx_byte),
    .tx_ready(tx_ready), .cts_in(cts_in), .rts_out(rts_out), .dtr_out(dtr_out),
    .irq_out(irq_out), .divisor(divisor), .frame_cfg(frame_cfg)
  );

  // entry: {req[3:0], is_read, offset[2:0], wdata[7:0], expected[7:0]}
  localparam int NV = 35;
  localparam logic [23:0] VEC [NV] = '{
    {4'd1, 1'b1, 3'd2, 8'h00, 8'h01},  // R1 IIR reset
    {4'd1, 1'b1, 3'd5, 8'h00, 8'h60},  // R1 LSR reset
    {4'd1, 1'b1, 3'd3, 8'h00, 8'h00},  // R1 LCR reset
    {4'd4, 1'b0, 3'd7, 8'hA5, 8'h00},  // R4 scratch write
    {4'd4, 1'b1, 3'd7, 8'h00, 8'hA5},  // R4 scratch read
    {4'd2, 1'b0, 3'd3, 8'h80, 8'h00},  // R2 open divisor bank
    {4'd2, 1'b0, 3'd0, 8'h34, 8'h00},
    {4'd2, 1'b0, 3'd1, 8'h12, 8'h00},
    {4'd2, 1'b1, 3'd0, 8'h00, 8'h34},
    {4'd2, 1'b1, 3'd1, 8'h00, 8'h12},
    {4'd2, 1'b0, 3'd3, 8'h03, 8'h00},  // R2 back to normal bank
    {4'd2, 1'b0, 3'd1, 8'h0F, 8'h00},
    {4'd2, 1'b1, 3'd1, 8'h00, 8'h0F},  // R2 IER
    {4'd13, 1'b1, 3'd3, 8'h00, 8'h03},
    {4'd3, 1'b0, 3'd3, 8'hBF, 8'h00},  // R3 enhanced bank
    {4'd3, 1'b0, 3'd2, 8'hC0, 8'h00},
    {4'd3, 1'b1, 3'd2, 8'h00, 8'hC0},
    {4'd3, 1'b1, 3'd7, 8'h00, 8'h00},
    {4'd3, 1'b0, 3'd7, 8'h11, 8'h00},
    {4'd3, 1'b0, 3'd2, 8'h00, 8'h00},
    {4'd3, 1'b1, 3'd2, 8'h00, 8'h00},
    {4'd3, 1'b0, 3'd3, 8'h03, 8'h00},
    {4'd3, 1'b1, 3'd7, 8'h00, 8'hA5},  // R3 scratch intact
    {4'd5, 1'b0, 3'd2, 8'h01, 8'h00},  // R5 enable queues
    {4'd5, 1'b1, 3'd2, 8'h00, 8'hC1},
    {4'd6, 1'b0, 3'd3, 8'h80, 8'h00},  // R6 deep under DLAB
    {4'd6, 1'b0, 3'd2, 8'h21, 8'h00},
    {4'd6, 1'b0, 3'd3, 8'h03, 8'h00},
    {4'd6, 1'b1, 3'd2, 8'h00, 8'hE1},
    {4'd6, 1'b0, 3'd2, 8'h01, 8'h00},  // R6 bit5 ignored without DLAB
    {4'd6, 1'b1, 3'd2, 8'h00, 8'hE1},
    {4'd6, 1'b0, 3'd3, 8'h80, 8'h00},
    {4'd6, 1'b0, 3'd2, 8'h01, 8'h00},
    {4'd6, 1'b0, 3'd3, 8'h03, 8'h00},
    {4'd6, 1'b1, 3'd2, 8'h00, 8'hC1}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); host_en = 1'b1; host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk); host_en = 1'b0; host_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); host_en = 1'b1; host_we = 1'b0; host_addr = a;
    @(negedge clk); host_en = 1'b0; d = host_rdata;
  endtask

  task automatic rd_chk(input string tag, input logic [2:0] a, input logic [7:0] exp);
    logic [7:0] v;
    bus_rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic ser_push(input logic [7:0] b);
    @(negedge clk); rx_valid = 1'b1; rx_byte = b;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    idle(4);
    rst = 1'b0;
    idle(1);
    // R1 outputs quiet after reset
    chk("R1 irq", {7'b0, irq_out}, 8'h00);
    chk("R1 rts/dtr", {6'b0, rts_out, dtr_out}, 8'h00);
    chk("R1 tx_valid", {7'b0, tx_valid}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      logic [7:0] v;
      if (VEC[i][19]) begin
        bus_rd(VEC[i][18:16], v);
        n_chk++;
        if (v !== VEC[i][7:0]) begin
          n_fail++;
          $display("FAIL R%0d vector %0d actual=%h expected=%h", VEC[i][23:20], i, v, VEC[i][7:0]);
        end
      end else begin
        bus_wr(VEC[i][18:16], VEC[i][15:8]);
      end
    end

    chk("R2 divisor hi", divisor[15:8], 8'h12);
    chk("R2 divisor lo", divisor[7:0], 8'h34);
    chk("R13 frame_cfg", {1'b0, frame_cfg}, 8'h03);

    // R7 oldest-first receive, shallow queue enabled
    ser_push(8'h11); ser_push(8'h22); ser_push(8'h33);
    rd_chk("R7 LSR ready", 3'd5, 8'h61);
    rd_chk("R7 first", 3'd0, 8'h11);
    rd_chk("R7 second", 3'd0, 8'h22);
    rd_chk("R7 third", 3'd0, 8'h33);
    rd_chk("R7 LSR drained", 3'd5, 8'h60);
    rd_chk("R7 empty read", 3'd0, 8'h00);

    // R9 overrun with queue disabled (capacity 1)
    bus_wr(3'd2, 8'h00);
    ser_push(8'h44); ser_push(8'h55);
    rd_chk("R9 LSR overrun", 3'd5, 8'h63);
    rd_chk("R9 LSR cleared", 3'd5, 8'h61);
    rd_chk("R9 kept byte", 3'd0, 8'h44);
    rd_chk("R9 dropped byte", 3'd5, 8'h60);

    // R8 transmit queue
    bus_wr(3'd0, 8'h9A);
    chk("R8 tx_valid", {7'b0, tx_valid}, 8'h01);
    chk("R8 tx_byte", tx_byte, 8'h9A);
    rd_chk("R8 LSR full", 3'd5, 8'h00);
    bus_wr(3'd0, 8'hBB);
    @(negedge clk); tx_ready = 1'b1;
    @(negedge clk); tx_ready = 1'b0;
    rd_chk("R8 LSR after pop", 3'd5, 8'h60);
    chk("R8 full write dropped", {7'b0, tx_valid}, 8'h00);
    bus_wr(3'd2, 8'h01);
    for (int k = 0; k < 15; k++) bus_wr(3'd0, 8'(k));
    rd_chk("R8 LSR room at 15", 3'd5, 8'h20);
    bus_wr(3'd0, 8'h0F);
    rd_chk("R8 LSR full at 16", 3'd5, 8'h00);
    chk("R8 head order", tx_byte, 8'h00);
    bus_wr(3'd2, 8'h05);
    rd_chk("R5 tx flush", 3'd5, 8'h60);
    ser_push(8'h01); ser_push(8'h02);
    bus_wr(3'd2, 8'h03);
    rd_chk("R5 rx flush", 3'd5, 8'h60);

    // R10 interrupt and identification
    bus_wr(3'd1, 8'h01);
    bus_wr(3'd4, 8'h08);
    ser_push(8'h5A);
    idle(1);
    chk("R10 irq level1", {7'b0, irq_out}, 8'h01);
    rd_chk("R10 IIR pending", 3'd2, 8'hC4);
    bus_wr(3'd4, 8'h00);
    idle(1);
    chk("R10 irq gated", {7'b0, irq_out}, 8'h00);
    bus_wr(3'd4, 8'h08);
    idle(1);
    chk("R10 irq regated", {7'b0, irq_out}, 8'h01);
    bus_wr(3'd2, 8'h41);
    idle(1);
    chk("R10 irq below 4", {7'b0, irq_out}, 8'h00);
    rd_chk("R10 IIR none", 3'd2, 8'hC1);
    ser_push(8'h01); ser_push(8'h02); ser_push(8'h03);
    idle(1);
    chk("R10 irq at 4", {7'b0, irq_out}, 8'h01);
    rd_chk("R10 pop", 3'd0, 8'h5A);
    idle(1);
    chk("R10 irq after pop", {7'b0, irq_out}, 8'h00);

    // R11 modem lines and automatic RTS
    bus_wr(3'd2, 8'h43);
    bus_wr(3'd4, 8'h03);
    idle(1);
    chk("R11 dtr/rts on", {6'b0, rts_out, dtr_out}, 8'h03);
    bus_wr(3'd4, 8'h23);
    for (int k = 0; k < 4; k++) ser_push(8'h70 + 8'(k));
    idle(1);
    chk("R11 auto rts drop", {6'b0, rts_out, dtr_out}, 8'h01);
    rd_chk("R11 pop", 3'd0, 8'h70);
    idle(1);
    chk("R11 auto rts back", {7'b0, rts_out}, 8'h01);
    bus_wr(3'd4, 8'h03);
    bus_wr(3'd3, 8'hBF); bus_wr(3'd2, 8'h40); bus_wr(3'd3, 8'h03);
    ser_push(8'h74);
    idle(1);
    chk("R11 enhanced rts drop", {7'b0, rts_out}, 8'h00);
    bus_wr(3'd3, 8'hBF); bus_wr(3'd2, 8'h00); bus_wr(3'd3, 8'h03);
    idle(1);
    chk("R11 rts without auto", {7'b0, rts_out}, 8'h01);

    // R12 CTS status and automatic CTS
    bus_wr(3'd2, 8'h47);
    cts_in = 1'b1;
    idle(2);
    rd_chk("R12 MSR delta", 3'd6, 8'h11);
    rd_chk("R12 MSR cleared", 3'd6, 8'h10);
    bus_wr(3'd4, 8'h23);
    cts_in = 1'b0;
    idle(2);
    bus_wr(3'd0, 8'h77);
    idle(1);
    chk("R12 held by cts", {7'b0, tx_valid}, 8'h00);
    cts_in = 1'b1;
    idle(2);
    chk("R12 released", {7'b0, tx_valid}, 8'h01);
    chk("R12 byte", tx_byte, 8'h77);
    cts_in = 1'b0;
    idle(2);
    chk("R12 held again", {7'b0, tx_valid}, 8'h00);
    bus_wr(3'd4, 8'h03);
    idle(1);
    chk("R12 auto off", {7'b0, tx_valid}, 8'h01);

    finish_run();
  end

endmodule